// File: doc/BRIEF.md
# SONET Framing Byte Aligner

This block sits behind a 1:8 deserializer whose byte boundary is arbitrary. It keeps the last few received bytes and looks for the SONET/SDH A1/A2 framing sequence at every one of the eight bit offsets at once. Once it finds the sequence, it selects that offset and emits byte-aligned data. With each output byte it gives two one-cycle status pulses: a sync pulse and a pattern-detect pulse. The serial stream is taken MSB first: bit 7 of each input byte is the earliest bit.

The boundary is locked. After a lock, a framing sequence that appears at another offset (for example, one formed across two payload bytes) moves nothing. A new lock can only follow a fresh low-to-high transition of the alignment enable. A size select picks the short two-byte sequence or the long four-byte sequence.

The controller is a three-state machine:
- ST_IDLE is entered at reset.
- ST_HUNT is entered from any state on an arming edge of the enable (transition "arm").
- ST_LOCK is entered from ST_HUNT on the first match (transition "capture").

Otherwise the state holds.

Top module: `sonet_byte_aligner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `dout`, `sync_pulse` and `pat_pulse` are 0. The boundary offset is 0, the byte history is cleared and the state is ST_IDLE.
- R2: A search is armed only by `align_en` being low in one cycle and high in the next. An enable already high when reset is released is not an arming edge. No status pulse occurs before the first arming edge.
- R3: With `wide_sel` = 0 the sequence is the 16 bits 0xF628. Inside a four-byte A1 A1 A2 A2 run, the inner A1 A2 pair therefore matches.
- R4: With `wide_sel` = 1 the sequence is the 32 bits 0xF6F62828. A lone 0xF628 does not match.
- R5: The first match after an arming edge adopts the match's bit offset. It raises `sync_pulse` and `pat_pulse` together for exactly one cycle. If several offsets match in the same cycle, the lowest one wins.
- R6: While locked, a match at the locked offset raises `pat_pulse` alone for one cycle.
- R7: While locked, a match at any other offset gives no pulse and leaves the boundary unchanged.
- R8: An arming edge while locked re-opens the search. The next match, at the same or another offset, pulses both outputs and moves the boundary.
- R9: Timing of `dout` and the pulses:
  - Input byte n is the byte presented in the cycle ending at edge n.
  - With offset k in force, `dout` after edge n holds the 8 stream bits that start k bits into input byte n−4.
  - Both status pulses come out on the same edge as the pattern's first (most significant) byte, with the new offset already applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel byte clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Unaligned byte from the deserializer, bit 7 earliest |
| wide_sel | input | 1 | 0: two-byte sequence, 1: four-byte sequence |
| align_en | input | 1 | Alignment enable; its rising edge arms a search |
| dout | output | 8 | Aligned byte |
| sync_pulse | output | 1 | One-cycle pulse when a boundary is adopted |
| pat_pulse | output | 1 | One-cycle pulse on each accepted sequence |

## Verification
On every cycle, the embedded assertions check the following:
- a sync pulse never comes without a pattern-detect pulse;
- the boundary register changes only on a cycle that also raises sync;
- an arming edge always lands the machine in the hunt state;
- nothing is reported out of the idle state.

The bench scenarios are needed for the rest:
- the exact output cycle of each pulse and the bit-exact aligned byte stream;
- that a second offset is ignored while locked and honoured after re-arming;
- the difference between the short and long sequences;
- that an enable held high through reset does not arm.

// File: rtl/sba_pkg.sv
package sba_pkg;
    localparam int BYTE_W  = 8;
    localparam int OFF_W   = $clog2(BYTE_W);
    localparam int HIST_N  = 4;
    localparam logic [BYTE_W-1:0] FRAME_HI = 8'hF6;
    localparam logic [BYTE_W-1:0] FRAME_LO = 8'h28;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_LOCK = 2'd2
    } sba_state_t;
endpackage

// File: rtl/sba_match.sv
module sba_match
    import sba_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [5*W-1:0] stream,
    input  logic           wide,
    output logic [W-1:0]   hit
);
    localparam int TOP = 5*W-1;

    for (genvar k = 0; k < W; k++) begin : g_off
        logic [W-1:0] b0, b1, b2, b3;
        logic         short_ok, long_ok;

        assign b0 = stream[TOP-k     -: W];
        assign b1 = stream[TOP-k-W   -: W];
        assign b2 = stream[TOP-k-2*W -: W];
        assign b3 = stream[TOP-k-3*W -: W];

        assign short_ok = (b0 == FRAME_HI) && (b1 == FRAME_LO);
        assign long_ok  = (b0 == FRAME_HI) && (b1 == FRAME_HI) &&
                          (b2 == FRAME_LO) && (b3 == FRAME_LO);
        assign hit[k]   = wide ? long_ok : short_ok;
    end
endmodule

// File: rtl/sba_shift.sv
module sba_shift
    import sba_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int OW = $clog2(W)
) (
    input  logic [W-1:0]  older,
    input  logic [W-1:0]  newer,
    input  logic [OW-1:0] off,
    output logic [W-1:0]  win
);
    logic [2*W-1:0] pair;

    assign pair = {older, newer};
    assign win  = pair[2*W-1-int'(off) -: W];
endmodule

// File: rtl/sba_ctrl.sv
module sba_ctrl
    import sba_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int OW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic [W-1:0]  hit,
    output logic [OW-1:0] off_sel,
    output logic          sync_o,
    output logic          pat_o
);
    sba_state_t    state, state_n;
    logic [OW-1:0] off_q;
    logic          sync_n, pat_n;
    logic [OW-1:0] low_off;

    always_comb begin
        low_off = '0;
        for (int i = W-1; i >= 0; i--) begin
            if (hit[i]) low_off = OW'(i);
        end
    end

    always_comb begin
        state_n = state;
        off_sel = off_q;
        sync_n  = 1'b0;
        pat_n   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_HUNT: begin
                if (|hit) begin
                    off_sel = low_off;
                    sync_n  = 1'b1;
                    pat_n   = 1'b1;
                    state_n = ST_LOCK;
                end
            end
            ST_LOCK: begin
                if (hit[off_q]) pat_n = 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
        if (arm) state_n = ST_HUNT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            off_q <= '0;
        end else begin
            state <= state_n;
            off_q <= off_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_o <= 1'b0;
            pat_o  <= 1'b0;
        end else begin
            sync_o <= sync_n;
            pat_o  <= pat_n;
        end
    end

    // R5
    sync_with_pat_chk: assert property (@(posedge clk) disable iff (rst)
        sync_o |-> pat_o);

    // R7
    off_moves_only_on_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(off_q) |-> sync_o);

    // R2
    arm_enters_hunt_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> (state == ST_HUNT));

    // R2
    idle_is_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> !pat_o);
endmodule

// File: rtl/sonet_byte_aligner.sv
module sonet_byte_aligner
    import sba_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] din,
    input  logic       wide_sel,
    input  logic       align_en,
    output logic [7:0] dout,
    output logic       sync_pulse,
    output logic       pat_pulse
);
    localparam int W  = BYTE_W;
    localparam int OW = OFF_W;
    localparam int HN = HIST_N;

    logic [W-1:0]   hist [HN];
    logic [5*W-1:0] stream;
    logic [W-1:0]   hit;
    logic [OW-1:0]  off_sel;
    logic [W-1:0]   win;
    logic           en_q;
    logic           arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HN; i++) hist[i] <= '0;
        end else begin
            hist[0] <= din;
            for (int i = 1; i < HN; i++) hist[i] <= hist[i-1];
        end
    end

    assign stream = {hist[3], hist[2], hist[1], hist[0], din};

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b1;
        else     en_q <= align_en;
    end

    assign arm = align_en & ~en_q;

    sba_match #(.W(W)) u_match (
        .stream (stream),
        .wide   (wide_sel),
        .hit    (hit)
    );

    sba_ctrl #(.W(W), .OW(OW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .hit     (hit),
        .off_sel (off_sel),
        .sync_o  (sync_pulse),
        .pat_o   (pat_pulse)
    );

    sba_shift #(.W(W), .OW(OW)) u_shift (
        .older (hist[3]),
        .newer (hist[2]),
        .off   (off_sel),
        .win   (win)
    );

    always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= win;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (dout == 8'h00 && !sync_pulse && !pat_pulse));
endmodule

// File: tb/sonet_byte_aligner_test.sv
module sonet_byte_aligner_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = 8'h00;
    logic       wide_sel = 1'b0;
    logic       align_en = 1'b0;
    logic [7:0] dout;
    logic       sync_pulse, pat_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5ns clk = ~clk;

    sonet_byte_aligner uut (
        .clk(clk), .rst(rst), .din(din), .wide_sel(wide_sel),
        .align_en(align_en), .dout(dout),
        .sync_pulse(sync_pulse), .pat_pulse(pat_pulse)
    );

    localparam int NCYC = 80;

    typedef struct {
        int         t;
        logic [7:0] b;
        bit         care_b;
        logic       s;
        logic       p;
        string      rq;
    } item_t;

    item_t     sb[$];
    logic      bits     [NCYC*8];
    logic      en_sched [NCYC];
    int        exp_off  [NCYC];
    logic      exp_sync [NCYC];
    logic      exp_pat  [NCYC];
    string     exp_req  [NCYC];

    task automatic check(string rq, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic clear_scn();
        for (int i = 0; i < NCYC*8; i++) bits[i] = 1'b0;
        for (int t = 0; t < NCYC; t++) begin
            en_sched[t] = 1'b0;
            exp_off[t]  = 0;
            exp_sync[t] = 1'b0;
            exp_pat[t]  = 1'b0;
            exp_req[t]  = "R9";
        end
    endtask

    task automatic plant(int p, logic [31:0] v, int n);
        for (int i = 0; i < n; i++) bits[p+i] = v[n-1-i];
    endtask

    task automatic set_en(int a, int b, logic v);
        for (int t = a; t <= b; t++) en_sched[t] = v;
    endtask

    task automatic set_off(int a, int b, int k);
        for (int t = a; t <= b; t++) exp_off[t] = k;
    endtask

    task automatic pulse(int t, logic s, logic p, string rq);
        exp_sync[t] = s;
        exp_pat[t]  = p;
        exp_req[t]  = rq;
    endtask

    function automatic logic [7:0] byte_at(int p);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7-i] = (p + i >= 0) ? bits[p+i] : 1'b0;
        return b;
    endfunction

    // Driver: applies one byte per cycle and pushes what must appear after that edge
    task automatic run_scn(int ncyc, logic wide, logic en_rst);
        item_t it;
        @(negedge clk);
        rst = 1'b1; din = 8'h00; wide_sel = wide; align_en = en_rst;
        repeat (3) @(negedge clk);
        // R1
        check("R1", "dout in reset", int'(dout), 0);
        check("R1", "sync in reset", int'(sync_pulse), 0);
        check("R1", "pat in reset", int'(pat_pulse), 0);
        rst = 1'b0;
        for (int t = 0; t < ncyc; t++) begin
            if (t > 0) @(negedge clk);
            din      = byte_at(8*t);
            align_en = en_sched[t];
            it.t      = t;
            it.care_b = (t >= 4);
            it.b      = byte_at(8*(t-4) + exp_off[t]);
            it.s      = exp_sync[t];
            it.p      = exp_pat[t];
            it.rq     = exp_req[t];
            sb.push_back(it);
        end
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compares each pushed item just after its edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1ns;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check(it.rq, $sformatf("sync t=%0d", it.t), int'(sync_pulse), int'(it.s));
                check(it.rq, $sformatf("pat t=%0d", it.t), int'(pat_pulse), int'(it.p));
                if (it.care_b)
                    check("R9", $sformatf("dout t=%0d", it.t), int'(dout), int'(it.b));
            end
        end
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // Scenario A: short sequence, lock, repeat, foreign offset, re-arm (R5 R6 R7 R8)
        clear_scn();
        set_en(2, 24, 1'b1);
        set_en(26, 39, 1'b1);
        set_en(42, NCYC-1, 1'b1);
        plant(8*10+3, 32'h0000F628, 16); pulse(14, 1, 1, "R5");
        plant(8*20+3, 32'h0000F628, 16); pulse(24, 0, 1, "R6");
        plant(8*28+3, 32'h0000F628, 16); pulse(32, 1, 1, "R8");
        plant(8*34+5, 32'h0000F628, 16); pulse(38, 0, 0, "R7");
        plant(8*46+5, 32'h0000F628, 16); pulse(50, 1, 1, "R8");
        plant(8*56+3, 32'h0000F628, 16); pulse(60, 0, 0, "R7");
        plant(8*62+5, 32'h0000F628, 16); pulse(66, 0, 1, "R6");
        set_off(14, 49, 3);
        set_off(50, NCYC-1, 5);
        run_scn(72, 1'b0, 1'b0);

        // Scenario B: long sequence, enable high across reset does not arm (R2 R4)
        clear_scn();
        set_en(0, 13, 1'b1);
        set_en(16, NCYC-1, 1'b1);
        plant(8*8+6,  32'hF6F62828, 32); pulse(12, 0, 0, "R2");
        plant(8*20+6, 32'hF6F62828, 32); pulse(24, 1, 1, "R4");
        plant(8*30+6, 32'h0000F628, 16); pulse(34, 0, 0, "R4");
        plant(8*40+6, 32'hF6F62828, 32); pulse(44, 0, 1, "R6");
        set_off(24, NCYC-1, 6);
        run_scn(52, 1'b1, 1'b1);

        // Scenario C: short mode finds the inner pair of a long run (R3)
        clear_scn();
        set_en(2, NCYC-1, 1'b1);
        plant(8*10+2, 32'hF6F62828, 32); pulse(15, 1, 1, "R3");
        set_off(15, NCYC-1, 2);
        run_scn(24, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule